// File: doc/BRIEF.md
# Snoop-Stall Latency Injector

This block sits on a split-phase shared bus and makes the host see the latency of a cache that exists only as a tag model. Each memory-access or invalidation transaction seen in its request phase is handed to one of eight trackers. The trackers are assigned in round-robin order. Each tracker follows its transaction through the error phase and asks an external lookup engine for a hit or miss verdict. It then holds the bus in the snoop phase by driving both snoop lines together for a programmed number of cycles. Snoop phases finish strictly in the order the transactions arrived, because each tracker waits for its predecessor's snoop to complete before it starts its own.

Two delay registers are loaded from a configuration strobe, one used for hits and one for misses. A delay of zero gives a transaction with no stall. An odd delay is rounded up, because the bus accepts stalls only in pairs of cycles. A transaction that fails its error phase is dropped without a lookup. It still passes the snoop turn on, so the trackers behind it are not blocked. A response strobe frees the oldest tracker that is waiting for its response.

Top module: `snoop_stall_injector`

## Requirements
- R1: While reset is held and after it is released, `busy` is all zero, both snoop lines are low and `lookup_req` is low. The first tracked request after reset goes to tracker 0, and tracker 0 may start its snoop without waiting for any predecessor.
- R2: Only `req_type` codes 0 (memory read), 1 (memory write) and 2 (invalidate) are tracked. For codes 3 to 7, no `busy` bit rises and no lookup is issued.
- R3: A tracked request sampled at a clock edge sets the `busy` bit of the granted tracker after that edge. The grant then moves on to the next tracker, and after tracker 7 it returns to tracker 0. At most one `busy` bit rises per cycle.
- R4: `lookup_req` is a single-cycle pulse. `lookup_id` names the tracker, and the verdict on `lk_hit` is taken in that same cycle. Lookups are issued in allocation order, and a tracker issues its lookup only after its predecessor's snoop has completed.
- R5: A stall drives `snp_hit` and `snp_hitm` high in the same cycle. The two lines never differ, and neither is high while no tracker is busy.
- R6: The number of stall cycles is the hit delay on a hit verdict, or the miss delay on a miss verdict, rounded up to the next even number. A selected delay of zero produces no stall on either path.
- R7: After the last stall cycle of one transaction there are at least two cycles with both snoop lines low. The next lookup comes no earlier than the third cycle after that stall cycle.
- R8: If `err_cancel` is high at the edge that follows the request edge, the transaction is cancelled. It gets no lookup and no stall, its tracker becomes free, and later transactions still complete their snoop phases.
- R9: A `resp_valid` pulse frees the oldest tracker that is waiting for its response, and that tracker's `busy` bit clears after the edge. An allocation in the same cycle also takes effect.
- R10: `cfg_we` loads `cfg_hit_dly` and `cfg_miss_dly` into the delay registers. Both registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request-phase strobe |
| req_type | input | TW | Transaction type code |
| err_cancel | input | 1 | Error-phase failure, one cycle after the request |
| lk_hit | input | 1 | Verdict from the lookup engine, valid with `lookup_req` |
| resp_valid | input | 1 | Response-phase strobe |
| cfg_we | input | 1 | Load strobe for the delay registers |
| cfg_hit_dly | input | DW | Hit delay in bus cycles |
| cfg_miss_dly | input | DW | Miss delay in bus cycles |
| lookup_req | output | 1 | Lookup request pulse |
| lookup_id | output | log2(NTRK) | Tracker that owns the lookup |
| snp_hit | output | 1 | Snoop hit line |
| snp_hitm | output | 1 | Snoop modified-hit line |
| busy | output | NTRK | One bit per tracker, high while the tracker holds a transaction |

## Verification
Allocation of a new transaction and retirement of the oldest one can happen on the same clock edge. They must not disturb each other, even when the grant lands on the tracker that was retired one cycle earlier. The bench first fills all eight trackers and frees one with a response. It then drives a new request and a response strobe in the same cycle, so that one tracker is refilled while the next oldest is freed. The result is judged on `busy`, which must show exactly the new bit set and the old one cleared. It is also judged on the lookup order and stall length that the scoreboard expects for the refilled tracker.

// File: rtl/snoop_stall_injector.sv
module snoop_stall_injector #(
  parameter int NTRK = 8,
  parameter int DW   = 8,
  parameter int TW   = 3,
  localparam int IW  = $clog2(NTRK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [TW-1:0]   req_type,
  input  logic            err_cancel,
  input  logic            lk_hit,
  input  logic            resp_valid,
  input  logic            cfg_we,
  input  logic [DW-1:0]   cfg_hit_dly,
  input  logic [DW-1:0]   cfg_miss_dly,
  output logic            lookup_req,
  output logic [IW-1:0]   lookup_id,
  output logic            snp_hit,
  output logic            snp_hitm,
  output logic [NTRK-1:0] busy
);

  typedef enum logic [3:0] {
    S_INIT, S_ERR, S_TAG, S_ST1, S_ST2, S_WAIT, S_VS1, S_VS2, S_RESP
  } trk_st_t;

  localparam logic [TW-1:0] TY_RD  = TW'(0);
  localparam logic [TW-1:0] TY_WR  = TW'(1);
  localparam logic [TW-1:0] TY_INV = TW'(2);

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] x);
    return (x == IW'(NTRK-1)) ? '0 : x + 1'b1;
  endfunction

  trk_st_t         st [NTRK];
  logic [NTRK-1:0] tok, cx, fresh;
  logic [NTRK-1:0] done, go, tagv, stv, canc;
  logic [IW-1:0]   gnt, rptr, ret_idx, scan;
  logic            ret_any, stalling;
  logic [DW-1:0]   hit_dly, miss_dly;
  logic [DW:0]     cnt, hit_even, miss_even, dly_sel;

  wire tracked = req_valid && (req_type == TY_RD || req_type == TY_WR || req_type == TY_INV);

  assign hit_even  = {1'b0, hit_dly}  + (DW+1)'(hit_dly[0]);
  assign miss_even = {1'b0, miss_dly} + (DW+1)'(miss_dly[0]);
  assign dly_sel   = lk_hit ? hit_even : miss_even;

  always_comb begin
    lookup_id = '0;
    for (int i = 0; i < NTRK; i++) begin
      done[i] = (st[i] == S_VS2);
      tagv[i] = (st[i] == S_TAG);
      stv[i]  = (st[i] == S_ST1) || (st[i] == S_ST2) || (st[i] == S_WAIT);
      busy[i] = (st[i] != S_INIT);
      canc[i] = cx[i] | (fresh[i] & err_cancel);
      if (tagv[i]) lookup_id = IW'(i);
    end
    for (int i = 0; i < NTRK; i++)
      go[i] = tok[i] | done[(i + NTRK - 1) % NTRK];
  end

  always_comb begin
    ret_any = 1'b0;
    ret_idx = rptr;
    scan    = rptr;
    for (int k = 0; k < NTRK; k++) begin
      if (!ret_any && st[scan] == S_RESP) begin
        ret_any = 1'b1;
        ret_idx = scan;
      end
      scan = nxt(scan);
    end
  end

  assign lookup_req = |tagv;
  assign stalling   = |stv;
  assign snp_hit    = stalling;
  assign snp_hitm   = stalling;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTRK; i++) st[i] <= S_INIT;
      tok      <= NTRK'(1);
      cx       <= '0;
      fresh    <= '0;
      gnt      <= '0;
      rptr     <= '0;
      cnt      <= '0;
      hit_dly  <= '0;
      miss_dly <= '0;
    end else begin
      if (cfg_we) begin
        hit_dly  <= cfg_hit_dly;
        miss_dly <= cfg_miss_dly;
      end
      if (tracked && st[gnt] == S_INIT) gnt <= nxt(gnt);
      if (resp_valid && ret_any)                 rptr <= nxt(ret_idx);
      else if (st[rptr] == S_INIT && rptr != gnt) rptr <= nxt(rptr);
      if (lookup_req)    cnt <= dly_sel;
      else if (stalling) cnt <= cnt - 1'b1;

      for (int i = 0; i < NTRK; i++) begin
        fresh[i] <= 1'b0;
        if (done[(i + NTRK - 1) % NTRK]) tok[i] <= 1'b1;
        case (st[i])
          S_INIT: if (tracked && gnt == IW'(i)) begin
            st[i]    <= S_ERR;
            fresh[i] <= 1'b1;
            cx[i]    <= 1'b0;
          end
          S_ERR: begin
            if (go[i]) begin
              tok[i] <= 1'b0;
              cx[i]  <= canc[i];
              st[i]  <= canc[i] ? S_VS2 : S_TAG;
            end else if (fresh[i] && err_cancel) begin
              cx[i] <= 1'b1;
            end
          end
          S_TAG:          st[i] <= (dly_sel == '0) ? S_VS1 : S_ST1;
          S_ST1:          st[i] <= S_ST2;
          S_ST2, S_WAIT:  st[i] <= (cnt == (DW+1)'(1)) ? S_VS1 : S_WAIT;
          S_VS1:          st[i] <= S_VS2;
          S_VS2: begin
            st[i] <= cx[i] ? S_INIT : S_RESP;
            cx[i] <= 1'b0;
          end
          S_RESP: if (resp_valid && ret_any && ret_idx == IW'(i)) st[i] <= S_INIT;
          default: st[i] <= S_INIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/snoop_stall_injector_chk.sv
module snoop_stall_injector_chk #(
  parameter int NTRK = 8,
  parameter int TW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [TW-1:0]   req_type,
  input logic            lookup_req,
  input logic            snp_hit,
  input logic            snp_hitm,
  input logic [NTRK-1:0] busy
);

  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)       run <= '0;
    else if (snp_hit) run <= run + 1'b1;
    else              run <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (busy == '0 && !snp_hit && !snp_hitm && !lookup_req));

  // R2
  ignored_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type > TW'(2)) |=> ($countones(busy) <= $countones($past(busy))));

  // R3
  single_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy & ~$past(busy)));

  // R4
  lookup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |=> !lookup_req);

  // R5
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit || snp_hitm) |-> (busy != '0));

  // R6
  even_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_hit && run != '0) |-> !run[0]);

  // R7
  clean_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |-> (!snp_hit && !$past(snp_hit) && !$past(snp_hit, 2)));

endmodule

bind snoop_stall_injector snoop_stall_injector_chk #(.NTRK(NTRK), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .lookup_req(lookup_req), .snp_hit(snp_hit), .snp_hitm(snp_hitm), .busy(busy)
);

// File: tb/snoop_stall_injector_tb_top.sv
module snoop_stall_injector_tb_top;
  localparam int NTRK = 8;
  localparam int DW   = 8;
  localparam int TW   = 3;
  localparam int IW   = $clog2(NTRK);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, err_cancel = 1'b0, resp_valid = 1'b0, cfg_we = 1'b0;
  logic [TW-1:0]   req_type = '0;
  logic [DW-1:0]   cfg_hit_dly = '0, cfg_miss_dly = '0;
  logic            lk_hit, lookup_req, snp_hit, snp_hitm;
  logic [IW-1:0]   lookup_id;
  logic [NTRK-1:0] busy;
  logic [NTRK-1:0] verdict = '0;

  assign lk_hit = verdict[lookup_id];

  snoop_stall_injector #(.NTRK(NTRK), .DW(DW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .err_cancel(err_cancel), .lk_hit(lk_hit), .resp_valid(resp_valid),
    .cfg_we(cfg_we), .cfg_hit_dly(cfg_hit_dly), .cfg_miss_dly(cfg_miss_dly),
    .lookup_req(lookup_req), .lookup_id(lookup_id),
    .snp_hit(snp_hit), .snp_hitm(snp_hitm), .busy(busy)
  );

  int checks = 0, errors = 0;
  int ap = 0, hd = 0, md = 0;
  int exp_id[$];
  int exp_len[$];
  int cyc = 0, last_stall = -100, run = 0, cur_len = 0, cur_id = 0, pair_bad = 0;
  bit counting = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd_even(input int d);
    return d + (d % 2);
  endfunction

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      err_cancel = 1'b0;
    end
  endtask

  task automatic cfg(input int h, input int m);
    @(negedge clk);
    err_cancel = 1'b0; cfg_we = 1'b1;
    cfg_hit_dly = DW'(h); cfg_miss_dly = DW'(m);
    @(negedge clk);
    cfg_we = 1'b0; hd = h; md = m;
  endtask

  task automatic issue(input int ty, input bit hit, input bit err, input bit with_resp);
    @(negedge clk);
    err_cancel = 1'b0; req_valid = 1'b1; req_type = TW'(ty); resp_valid = with_resp;
    if (ty <= 2) begin
      verdict[ap] = hit;
      if (!err) begin
        exp_id.push_back(ap);
        exp_len.push_back(rnd_even(hit ? hd : md));
      end
      ap = (ap + 1) % NTRK;
    end
    @(negedge clk);
    req_valid = 1'b0; resp_valid = 1'b0; err_cancel = err;
  endtask

  task automatic respond();
    @(negedge clk);
    err_cancel = 1'b0; resp_valid = 1'b1;
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (snp_hit !== snp_hitm) pair_bad++;
      if (snp_hit) last_stall = cyc;
      if (counting) begin
        if (snp_hit) run++;
        else begin
          check(run == cur_len, $sformatf("R6 stall length tracker %0d", cur_id), run, cur_len);
          counting = 1'b0;
        end
      end
      if (lookup_req) begin
        check(cyc - last_stall >= 3, "R7 clean gap before lookup", cyc - last_stall, 3);
        if (exp_id.size() == 0) begin
          check(1'b0, "R4 unexpected lookup", int'(lookup_id), -1);
        end else begin
          cur_id  = exp_id.pop_front();
          cur_len = exp_len.pop_front();
          check(int'(lookup_id) == cur_id, "R4 lookup order", int'(lookup_id), cur_id);
          counting = 1'b1;
          run = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R4 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    tick(4);
    check(busy == '0 && !snp_hit && !lookup_req, "R1 idle in reset", int'(busy), 0);
    rst_n = 1'b1;
    tick(2);
    check(busy == '0 && !snp_hit, "R1 idle after reset", int'(busy), 0);

    // R10: delay registers reset to zero -> miss with no stall; R1 first goes to tracker 0
    issue(0, 1'b0, 1'b0, 1'b0);
    check(busy == 8'h01, "R1 first tracker 0 / R3 busy", int'(busy), 1);
    tick(10);
    respond();
    check(busy == '0, "R9 retire frees tracker", int'(busy), 0);

    // R6 hit delay zero, miss delay 4
    cfg(0, 4);
    issue(1, 1'b1, 1'b0, 1'b0);
    issue(0, 1'b0, 1'b0, 1'b0);
    tick(20);
    check(busy == 8'h06, "R3 round-robin ids 1 and 2", int'(busy), 6);
    respond();
    check(busy == 8'h04, "R9 oldest retired first", int'(busy), 4);
    respond();

    // R6 odd delays rounded up
    cfg(3, 5);
    issue(2, 1'b1, 1'b0, 1'b0);
    issue(0, 1'b0, 1'b0, 1'b0);
    tick(30);
    respond(); respond();

    // R6 zero miss delay, even hit delay
    cfg(2, 0);
    issue(0, 1'b0, 1'b0, 1'b0);
    issue(1, 1'b1, 1'b0, 1'b0);
    tick(20);
    respond(); respond();
    check(busy == '0, "R9 all retired", int'(busy), 0);

    // R2 ignored types
    issue(5, 1'b0, 1'b0, 1'b0);
    check(busy == '0, "R2 type 5 ignored", int'(busy), 0);
    issue(7, 1'b0, 1'b0, 1'b0);
    tick(10);
    check(busy == '0 && !snp_hit, "R2 type 7 ignored", int'(busy), 0);

    // R8 standalone cancel (tracker 7)
    issue(2, 1'b1, 1'b1, 1'b0);
    tick(10);
    check(busy == '0, "R8 cancelled tracker freed", int'(busy), 0);

    // R8 cancel behind a long stall, successor continues (trackers 0,1,2)
    cfg(0, 10);
    issue(0, 1'b0, 1'b0, 1'b0);
    issue(2, 1'b0, 1'b1, 1'b0);
    issue(1, 1'b1, 1'b0, 1'b0);
    tick(40);
    check(busy == 8'h05, "R8 cancelled middle freed, chain continues", int'(busy), 5);
    respond();
    check(busy == 8'h04, "R9 retire skips cancelled slot", int'(busy), 4);
    respond();
    check(busy == '0, "R9 last retired", int'(busy), 0);

    // R3 eight outstanding with wrap (trackers 3..7,0,1,2)
    cfg(0, 2);
    for (int k = 0; k < 8; k++) issue(0, 1'b0, 1'b0, 1'b0);
    check(busy == 8'hFF, "R3 eight outstanding", int'(busy), 255);
    tick(60);
    respond();
    check(busy == 8'hF7, "R9 oldest tracker 3 retired", int'(busy), 247);

    // R9 allocation and retirement in the same cycle
    issue(0, 1'b0, 1'b0, 1'b1);
    check(busy == 8'hEF, "R9 same-cycle alloc of 3 and retire of 4", int'(busy), 239);
    tick(20);
    for (int k = 0; k < 7; k++) respond();
    check(busy == '0, "R9 drained", int'(busy), 0);
    tick(5);

    check(exp_id.size() == 0, "R4 every expected lookup seen", exp_id.size(), 0);
    check(pair_bad == 0, "R5 snoop lines always paired", pair_bad, 0);
    check(!counting, "R6 no unfinished stall", int'(counting), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule